// File: doc/BRIEF.md
# Tagged Sample FIFO with Dual-Mode Overflow

This block buffers 16-bit words, each a 4-bit tag above a 12-bit payload, for a host that drains them one word per read strobe. Words come from one of two producers, chosen by a mode input. The first is a stream of converter results. In this mode the buffer holds at most 15 words. When it is full, a new word pushes out the oldest one, and a sticky overflow flag records that data was lost. The second producer is a burst of table words. In this mode the buffer holds up to 16 words and never accepts a write that would overflow it. The overflow bit then simply shows whether the buffer is full at that moment.

The block also supplies a 4-bit status word for the host. It carries two busy indications passed in from neighbouring units, plus the empty and overflow flags. Reading the status clears the sticky overflow flag. A software clear discards all stored words. A host read of an empty buffer does not stall: it returns a marker word that carries the status bits.

Top module: `tag_sample_fifo`

## Requirements
- R1: A written word is stored as `{tag, payload}`, with the tag in bits 15:12 and the payload in bits 11:0. Words are read back in the order they were written.
- R2: In converter mode (`mode_tbl`=0), at most 15 words are held. A write to a full buffer with no read in the same cycle discards the oldest word, so the buffer keeps the 15 most recent ones.
- R3: In table mode (`mode_tbl`=1), up to 16 words are held. A write to a full buffer with no read in the same cycle is dropped, and the stored words are unchanged.
- R4: In converter mode, `status[0]` (overflow) is set by a discarding write. It stays set until a cycle with `stat_rd` or `sw_clr`. Reading the buffer down to empty does not clear it. If a discard and `stat_rd` occur in the same cycle, the flag stays set.
- R5: In table mode, `status[0]` is 1 exactly when 16 words are held. It is not latched.
- R6: `status[1]` (empty) is 1 after reset and whenever no word is held. Any accepted write clears it. `sw_clr` discards all words and sets it.
- R7: A read while the buffer is empty returns `{4'hF, 8'h00, status}`, using the status value of the read cycle.
- R8: In converter mode, writes are ignored while `mon_en` is 0. In table mode, `mon_en` has no effect.
- R9: `status[3]` follows `adc_busy` and `status[2]` follows `alu_busy` in the same cycle.
- R10: A read and a write in the same cycle both take effect and leave the occupancy unchanged. This includes a full buffer in converter mode, where the read returns the oldest word and the overflow flag is not set.
- R11: `rd_word` is registered. It takes the new value on the clock edge that samples `rd_en` and holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_tbl | input | 1 | 0 = converter results, 1 = table words |
| mon_en | input | 1 | Allows converter-mode writes |
| wr_en | input | 1 | Write strobe |
| wr_tag | input | 4 | Tag of the word being written |
| wr_pay | input | 12 | Payload of the word being written |
| rd_en | input | 1 | Host read strobe |
| rd_word | output | 16 | Word returned by the last read |
| sw_clr | input | 1 | Software clear of the buffer and the sticky flag |
| stat_rd | input | 1 | Status read strobe; clears the sticky overflow flag |
| adc_busy | input | 1 | Converter busy indication |
| alu_busy | input | 1 | Arithmetic unit busy indication |
| status | output | 4 | Status word: {adc_busy, alu_busy, empty, overflow} |

## Verification
The properties assume three things about the inputs. The mode changes only while the buffer is empty. `sw_clr` is never asserted in the same cycle as `rd_en`. Words from the two producers are never mixed in the buffer. The stimulus meets these conditions by clearing the buffer before every mode change and by driving the clear in a cycle of its own. A reference queue in the bench computes the expected words and flags cycle by cycle.

// File: rtl/tsf_pkg.sv
package tsf_pkg;
   typedef enum logic {
      MODE_ADC = 1'b0,
      MODE_TBL = 1'b1
   } fifo_mode_e;

   typedef struct packed {
      logic adc_busy;
      logic alu_busy;
      logic empty;
      logic ovr;
   } stat_t;

   localparam int STAT_W = 4;
endpackage

// File: rtl/tsf_ctrl.sv
module tsf_ctrl #(
   parameter int DEPTH = 16,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode_tbl,
   input  logic             mon_en,
   input  logic             wr_en,
   input  logic             rd_en,
   input  logic             sw_clr,
   output logic [PTR_W-1:0] wr_ptr,
   output logic [PTR_W-1:0] rd_ptr,
   output logic [CNT_W-1:0] occ,
   output logic             do_wr,
   output logic             ovf_evt,
   output logic             full_tbl
);
   localparam int ADC_DEPTH = DEPTH - 1;
   localparam logic [CNT_W-1:0] CAP_TBL = CNT_W'(DEPTH);
   localparam logic [CNT_W-1:0] CAP_ADC = CNT_W'(ADC_DEPTH);

   logic [PTR_W-1:0] wr_nxt, rd_nxt;
   logic pop, acc, drop, full_adc;

   // Pointer wrap: free running when the depth is a power of two.
   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_wrap_pow2
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap_cmp
         assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_comb begin
      full_tbl = (occ == CAP_TBL);
      full_adc = (occ >= CAP_ADC);
      pop      = rd_en & (occ != '0);
      acc      = wr_en & (mode_tbl ? (~full_tbl | pop) : mon_en);
      drop     = acc & ~pop & ~mode_tbl & full_adc;
      do_wr    = acc & ~sw_clr;
      ovf_evt  = drop & ~sw_clr;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         occ    <= '0;
      end else if (sw_clr) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         occ    <= '0;
      end else begin
         if (acc) wr_ptr <= wr_nxt;
         if (pop | drop) rd_ptr <= rd_nxt;
         case ({acc & ~drop, pop})
            2'b10:   occ <= occ + 1'b1;
            2'b01:   occ <= occ - 1'b1;
            default: occ <= occ;
         endcase
      end
   end
endmodule

// File: rtl/tsf_store.sv
module tsf_store #(
   parameter int DEPTH  = 16,
   parameter int WORD_W = 16,
   localparam int PTR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [PTR_W-1:0]  waddr,
   input  logic [WORD_W-1:0] wdata,
   input  logic [PTR_W-1:0]  raddr,
   output logic [WORD_W-1:0] rdata
);
   logic [WORD_W-1:0] slot [DEPTH];

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_slot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                            slot[i] <= '0;
            else if (we && waddr == PTR_W'(i))     slot[i] <= wdata;
         end
      end
   endgenerate

   assign rdata = slot[raddr];
endmodule

// File: rtl/tsf_flags.sv
module tsf_flags
   import tsf_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  mode_tbl,
   input  logic  ovf_evt,
   input  logic  stat_rd,
   input  logic  sw_clr,
   input  logic  full_tbl,
   input  logic  empty,
   input  logic  adc_busy,
   input  logic  alu_busy,
   output stat_t stat
);
   logic sticky;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sticky <= 1'b0;
      else if (sw_clr) sticky <= 1'b0;
      else             sticky <= (sticky & ~stat_rd) | ovf_evt;
   end

   always_comb begin
      stat.adc_busy = adc_busy;
      stat.alu_busy = alu_busy;
      stat.empty    = empty;
      stat.ovr      = (mode_tbl == MODE_TBL) ? full_tbl : sticky;
   end
endmodule

// File: rtl/tag_sample_fifo.sv
module tag_sample_fifo
   import tsf_pkg::*;
#(
   parameter int TAG_W     = 4,
   parameter int PAY_W     = 12,
   parameter int TBL_DEPTH = 16,
   localparam int WORD_W = TAG_W + PAY_W,
   localparam int PTR_W  = $clog2(TBL_DEPTH),
   localparam int CNT_W  = $clog2(TBL_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_tbl,
   input  logic              mon_en,
   input  logic              wr_en,
   input  logic [TAG_W-1:0]  wr_tag,
   input  logic [PAY_W-1:0]  wr_pay,
   input  logic              rd_en,
   output logic [WORD_W-1:0] rd_word,
   input  logic              sw_clr,
   input  logic              stat_rd,
   input  logic              adc_busy,
   input  logic              alu_busy,
   output logic [STAT_W-1:0] status
);
   generate
      if (TAG_W < 1) begin : g_bad_tag
         $error("tag_sample_fifo: TAG_W must be at least 1");
      end
      if (PAY_W < STAT_W) begin : g_bad_pay
         $error("tag_sample_fifo: PAY_W must hold the status word");
      end
      if (TBL_DEPTH < 2) begin : g_bad_depth
         $error("tag_sample_fifo: TBL_DEPTH must be at least 2");
      end
   endgenerate

   localparam logic [WORD_W-1:0] EMPTY_HDR = {{TAG_W{1'b1}}, {PAY_W{1'b0}}};

   logic [PTR_W-1:0]  wr_ptr, rd_ptr;
   logic [CNT_W-1:0]  occ;
   logic              do_wr, ovf_evt, full_tbl, empty;
   logic [WORD_W-1:0] head;
   stat_t             stat;

   tsf_ctrl #(.DEPTH(TBL_DEPTH)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .mode_tbl(mode_tbl), .mon_en(mon_en),
      .wr_en(wr_en), .rd_en(rd_en), .sw_clr(sw_clr),
      .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .occ(occ), .do_wr(do_wr),
      .ovf_evt(ovf_evt), .full_tbl(full_tbl)
   );

   tsf_store #(.DEPTH(TBL_DEPTH), .WORD_W(WORD_W)) u_store (
      .clk(clk), .rst_n(rst_n), .we(do_wr), .waddr(wr_ptr),
      .wdata({wr_tag, wr_pay}), .raddr(rd_ptr), .rdata(head)
   );

   assign empty = (occ == '0);

   tsf_flags u_flags (
      .clk(clk), .rst_n(rst_n), .mode_tbl(mode_tbl), .ovf_evt(ovf_evt),
      .stat_rd(stat_rd), .sw_clr(sw_clr), .full_tbl(full_tbl),
      .empty(empty), .adc_busy(adc_busy), .alu_busy(alu_busy), .stat(stat)
   );

   assign status = stat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_word <= '0;
      else if (rd_en && !sw_clr)
         rd_word <= empty ? (EMPTY_HDR | WORD_W'(status)) : head;
   end
endmodule

// File: rtl/tsf_chk.sv
module tsf_chk #(
   parameter int TBL_DEPTH = 16,
   parameter int WORD_W    = 16,
   parameter int TAG_W     = 4,
   localparam int CNT_W = $clog2(TBL_DEPTH + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mode_tbl,
   input logic              mon_en,
   input logic              wr_en,
   input logic              rd_en,
   input logic              sw_clr,
   input logic              stat_rd,
   input logic [3:0]        status,
   input logic [WORD_W-1:0] rd_word,
   input logic [CNT_W-1:0]  occ
);
   localparam logic [CNT_W-1:0] ADC_CAP = CNT_W'(TBL_DEPTH - 1);

   // R6
   clr_sets_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sw_clr |=> status[1]);

   // R4
   sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_tbl && status[0] && !stat_rd && !sw_clr) |=> (mode_tbl || status[0]));

   // R5
   tbl_empty_no_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_tbl && status[1]) |-> !status[0]);

   // R7
   empty_read_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !sw_clr && status[1]) |=> (rd_word[WORD_W-1 -: TAG_W] == {TAG_W{1'b1}}));

   // R8
   mon_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_tbl && !mon_en && !rd_en && !sw_clr && status[1]) |=> status[1]);

   // R2
   adc_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_tbl && !sw_clr && occ <= ADC_CAP) |=> (mode_tbl || occ <= ADC_CAP));

   // R10
   rdwr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_tbl && mon_en && wr_en && rd_en && !sw_clr && occ != '0) |=> $stable(occ));
endmodule

bind tag_sample_fifo tsf_chk #(
   .TBL_DEPTH(TBL_DEPTH), .WORD_W(WORD_W), .TAG_W(TAG_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .mode_tbl(mode_tbl), .mon_en(mon_en),
   .wr_en(wr_en), .rd_en(rd_en), .sw_clr(sw_clr), .stat_rd(stat_rd),
   .status(status), .rd_word(rd_word), .occ(occ)
);

// File: tb/tag_sample_fifo_test.sv
module tag_sample_fifo_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_tbl = 1'b0, mon_en = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
   logic [3:0]  wr_tag = '0;
   logic [11:0] wr_pay = '0;
   logic        sw_clr = 1'b0, stat_rd = 1'b0, adc_busy = 1'b0, alu_busy = 1'b0;
   logic [15:0] rd_word;
   logic [3:0]  status;

   int nchk = 0, nfail = 0;
   logic [15:0] q[$];
   logic        m_sticky = 1'b0;

   always #2 clk = ~clk;

   tag_sample_fifo uut (
      .clk(clk), .rst_n(rst_n), .mode_tbl(mode_tbl), .mon_en(mon_en),
      .wr_en(wr_en), .wr_tag(wr_tag), .wr_pay(wr_pay), .rd_en(rd_en),
      .rd_word(rd_word), .sw_clr(sw_clr), .stat_rd(stat_rd),
      .adc_busy(adc_busy), .alu_busy(alu_busy), .status(status)
   );

   function automatic logic [3:0] m_status();
      logic ov;
      ov = mode_tbl ? (q.size() == 16) : m_sticky;
      return {adc_busy, alu_busy, q.size() == 0, ov};
   endfunction

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // One clock cycle of stimulus, with the reference queue updated alongside.
   task automatic step(input logic wr, input logic [15:0] w, input logic rd,
                       input logic clr, input logic srd, input string req);
      logic [15:0] exp_rd;
      logic        pop, acc;
      @(negedge clk);
      wr_en = wr; wr_tag = w[15:12]; wr_pay = w[11:0];
      rd_en = rd; sw_clr = clr; stat_rd = srd;
      exp_rd = (q.size() == 0) ? {4'hF, 8'h00, m_status()} : q[0];
      @(posedge clk);
      #1;
      wr_en = 1'b0; rd_en = 1'b0; sw_clr = 1'b0; stat_rd = 1'b0;
      if (clr) begin
         q.delete();
         m_sticky = 1'b0;
      end else begin
         pop = rd && q.size() > 0;
         acc = wr && (mode_tbl ? (q.size() < 16 || pop) : mon_en);
         if (srd) m_sticky = 1'b0;
         if (pop) void'(q.pop_front());
         if (acc) q.push_back(w);
         if (!mode_tbl && q.size() > 15) begin
            void'(q.pop_front());
            m_sticky = 1'b1;
         end
      end
      if (rd && !clr) check({req, " read word"}, rd_word, exp_rd);
      check({req, " status"}, {12'h0, status}, {12'h0, m_status()});
   endtask

   function automatic logic [15:0] pat(input int k);
      return {4'(k), 12'((k * 157 + 3) & 12'hFFF)};
   endfunction

   initial begin
      #(4 * 200000);
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   initial begin
      logic [15:0] held;
      repeat (3) @(posedge clk);
      #1;
      // R6: reset state
      check("R6 reset status", {12'h0, status}, 16'h0002);
      check("R6 reset word", rd_word, 16'h0000);
      @(negedge clk);
      rst_n = 1'b1;

      // R9: busy inputs, all four combinations
      for (int a = 0; a < 4; a++) begin
         adc_busy = a[1]; alu_busy = a[0];
         #1;
         check("R9 busy bits", {12'h0, status}, {12'h0, a[1], a[0], 2'b10});
      end
      adc_busy = 1'b0; alu_busy = 1'b0;

      // R8: monitoring disabled, converter writes ignored
      for (int k = 0; k < 3; k++) step(1'b1, pat(k), 1'b0, 1'b0, 1'b0, "R8");
      mon_en = 1'b1;

      // R1 / R11: all sixteen tag values round trip in order
      for (int k = 0; k < 15; k++) step(1'b1, pat(k + 1), 1'b0, 1'b0, 1'b0, "R1");
      for (int k = 0; k < 15; k++) step(1'b0, 16'h0, 1'b1, 1'b0, 1'b0, "R1");
      step(1'b1, 16'h0ABC, 1'b0, 1'b0, 1'b0, "R1");
      step(1'b0, 16'h0, 1'b1, 1'b0, 1'b0, "R1");
      held = rd_word;
      step(1'b0, 16'h0, 1'b0, 1'b0, 1'b0, "R11");
      check("R11 word held", rd_word, held);

      // R7: empty read marker, with both busy patterns
      step(1'b0, 16'h0, 1'b1, 1'b0, 1'b0, "R7");
      check("R7 marker idle", rd_word, 16'hF002);
      adc_busy = 1'b1;
      step(1'b0, 16'h0, 1'b1, 1'b0, 1'b0, "R7");
      check("R7 marker busy", rd_word, 16'hF00A);
      adc_busy = 1'b0;

      // R2 / R4: overflow in converter mode, sticky through draining
      for (int k = 0; k < 20; k++) step(1'b1, pat(k * 3), 1'b0, 1'b0, 1'b0, "R2");
      check("R2 overflow set", {15'h0, status[0]}, 16'h1);
      for (int k = 0; k < 15; k++) step(1'b0, 16'h0, 1'b1, 1'b0, 1'b0, "R2");
      check("R4 sticky after drain", {14'h0, status[1:0]}, 16'h3);
      step(1'b0, 16'h0, 1'b0, 1'b0, 1'b1, "R4");
      check("R4 cleared by status read", {15'h0, status[0]}, 16'h0);

      // R4: discard and status read in the same cycle keep the flag
      for (int k = 0; k < 15; k++) step(1'b1, pat(k + 40), 1'b0, 1'b0, 1'b0, "R4");
      step(1'b1, pat(99), 1'b0, 1'b0, 1'b1, "R4");
      check("R4 set wins", {15'h0, status[0]}, 16'h1);

      // R6: software clear discards and resets overflow
      step(1'b0, 16'h0, 1'b0, 1'b1, 1'b0, "R6");
      check("R6 clear", {12'h0, status}, 16'h0002);
      step(1'b0, 16'h0, 1'b1, 1'b0, 1'b0, "R6");

      // R10: simultaneous read and write, not full and full
      for (int k = 0; k < 3; k++) step(1'b1, pat(k + 60), 1'b0, 1'b0, 1'b0, "R10");
      for (int k = 0; k < 4; k++) step(1'b1, pat(k + 70), 1'b1, 1'b0, 1'b0, "R10");
      for (int k = 3; k < 15; k++) step(1'b1, pat(k + 80), 1'b0, 1'b0, 1'b0, "R10");
      for (int k = 0; k < 3; k++) step(1'b1, pat(k + 120), 1'b1, 1'b0, 1'b0, "R10");
      check("R10 no overflow", {15'h0, status[0]}, 16'h0);
      for (int k = 0; k < 16; k++) step(1'b0, 16'h0, 1'b1, 1'b0, 1'b0, "R10");

      // R3 / R5 / R8: table mode, mon_en ignored
      step(1'b0, 16'h0, 1'b0, 1'b1, 1'b0, "R3");
      mode_tbl = 1'b1;
      mon_en = 1'b0;
      for (int k = 0; k < 15; k++) step(1'b1, pat(k + 200), 1'b0, 1'b0, 1'b0, "R5");
      check("R5 not full", {15'h0, status[0]}, 16'h0);
      step(1'b1, pat(215), 1'b0, 1'b0, 1'b0, "R5");
      check("R5 full shown", {15'h0, status[0]}, 16'h1);
      step(1'b1, pat(777), 1'b0, 1'b0, 1'b0, "R3");
      step(1'b1, pat(778), 1'b0, 1'b0, 1'b0, "R3");
      step(1'b0, 16'h0, 1'b1, 1'b0, 1'b0, "R3");
      check("R5 live after read", {15'h0, status[0]}, 16'h0);
      step(1'b1, pat(300), 1'b1, 1'b0, 1'b0, "R10");
      for (int k = 0; k < 17; k++) step(1'b0, 16'h0, 1'b1, 1'b0, 1'b0, "R3");
      step(1'b0, 16'h0, 1'b0, 1'b1, 1'b0, "R6");
      mode_tbl = 1'b0;

      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end
endmodule